// File: doc/BRIEF.md
# Immediate-Offset Load Decoder and Address Generator

This block takes one 32-bit load instruction word at a time and turns it into a single memory read plus the register updates that follow it. It recognises three addressing forms of a load-register-with-immediate instruction: post-increment, pre-increment and scaled positive offset. It reads the base value from a register-file read port, or from a dedicated stack-pointer input when the base index is 31. It issues one read request with a byte address and an access width. When the read data comes back, it pulses a destination write, and in the increment forms it also pulses a base write in the same cycle.

Instructions enter over a valid/ready stream. The block accepts a new word only when it is idle, so `in_ready` stays low from acceptance until the final write pulse. The memory request is valid/ready as well. Once `mreq_valid` rises, address and width stay unchanged until `mreq_ready` is seen high at a clock edge. The response is accepted only while `mrsp_ready` is high. Words outside the three forms, and a stack-pointer base that is not 16-byte aligned, end with a one-cycle flag instead of a request.

Top module: `ldimm_agu`

## Requirements
- R1: A word is accepted only if all of these hold: bits [29:27]=111, bit 26=0, bits [23:22]=01 and bit 31=1 (size field 10 = 32-bit, 11 = 64-bit). The form is one of two. In the increment forms, bits [25:24]=00, bit 21=0 and bits [11:10] are 01 (post) or 11 (pre). In the scaled form, bits [25:24]=01. Any other word pulses `flt_undef` for one cycle, raises no request and makes no register write.
- R2: Post-increment (imm9 in bits [20:12], sign-extended, not scaled): the request address is the unmodified base, and the base is written back with base + offset.
- R3: Pre-increment (same imm9 rules): the request address is base + offset, and that same value is written back to the base.
- R4: Scaled form (imm12 in bits [21:10]): the offset is imm12 zero-extended and shifted left by 2 for 32-bit loads or by 3 for 64-bit loads. The request address is base + offset, and no base write occurs.
- R5: `rf_rd_idx` carries the base index (bits [9:5]). When that index is 31, the base value comes from `sp_value`, and a base write-back is marked with `base_is_sp`=1.
- R6: With base index 31, a `sp_value` whose low 4 bits are not all zero pulses `flt_align` for one cycle, with no request and no register write. A misaligned general-register base raises no fault.
- R7: `mreq_dw` is 1 for 64-bit loads and 0 for 32-bit loads. For a 32-bit load, `dst_data` is the low 32 response bits, zero-extended.
- R8: In an increment form where the base index equals the destination index (bits [4:0]) and is not 31, the base write is suppressed and only the destination is written.
- R9: Back-pressure: a raised `mreq_valid` keeps address and width stable until `mreq_ready` is sampled high, and `in_ready` is low from acceptance until the access completes.
- R10: `dst_we` rises for exactly one cycle, in the cycle after the response handshake. `base_we`, when due, pulses in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Block idle and able to accept a word |
| in_word | input | 32 | Instruction word |
| rf_rd_idx | output | 5 | Register-file read index (base) |
| rf_rd_data | input | 64 | Register-file read data, combinational |
| sp_value | input | 64 | Current stack-pointer value |
| mreq_valid | output | 1 | Memory read request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 64 | Byte address of the read |
| mreq_dw | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mrsp_valid | input | 1 | Read data valid |
| mrsp_ready | output | 1 | Block waiting for read data |
| mrsp_data | input | 64 | Read data |
| dst_we | output | 1 | Destination write pulse |
| dst_idx | output | 5 | Destination register index |
| dst_data | output | 64 | Zero-extended load result |
| base_we | output | 1 | Base write-back pulse |
| base_is_sp | output | 1 | Write-back targets the stack pointer |
| base_idx | output | 5 | Base register index |
| base_data | output | 64 | Write-back value |
| flt_align | output | 1 | Stack-pointer misalignment pulse |
| flt_undef | output | 1 | Unrecognised encoding pulse |

## Verification
The hardest cases to reach from the ports are those where two index rules meet. One is base index equal to destination index, where the base write must vanish (R8). The other is both indices at 31, where the stack-pointer write must survive. The stimulus table builds words with chosen index pairs on purpose. It also includes a base near the top of the 64-bit range, so the write-back value wraps. Directed tests then hold `mreq_ready` low for several cycles to check request stability, and feed misaligned stack values in both the increment and scaled forms.

// File: rtl/ldimm_pkg.sv
package ldimm_pkg;
  localparam int XLEN      = 64;
  localparam int IDX_W     = 5;
  localparam int IMM_S_W   = 9;
  localparam int IMM_U_W   = 12;
  localparam int SP_INDEX  = 31;

  typedef enum logic [1:0] {
    FORM_POST = 2'd0,
    FORM_PRE  = 2'd1,
    FORM_UOFF = 2'd2,
    FORM_NONE = 2'd3
  } form_e;

  typedef struct packed {
    logic             legal;
    form_e            form;
    logic             is64;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rt;
    logic [XLEN-1:0]  offset;
    logic             wb_en;
    logic             base_sp;
  } dec_t;
endpackage

// File: rtl/ldimm_decode.sv
module ldimm_decode
  import ldimm_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec
);
  logic       common_ok;
  logic       size_ok;
  logic       idx_shape;
  logic       is_post;
  logic       is_pre;
  logic       is_uoff;
  logic [1:0] scale;
  logic [XLEN-1:0] off_s;
  logic [XLEN-1:0] off_u;

  // fixed fields shared by all three forms
  assign common_ok = (word[29:27] == 3'b111) && !word[26] && (word[23:22] == 2'b01);
  assign size_ok   = word[31];
  assign scale     = word[31:30];

  assign idx_shape = (word[25:24] == 2'b00) && !word[21];
  assign is_post   = idx_shape && (word[11:10] == 2'b01);
  assign is_pre    = idx_shape && (word[11:10] == 2'b11);
  assign is_uoff   = (word[25:24] == 2'b01);

  assign off_s = {{(XLEN-IMM_S_W){word[20]}}, word[20:12]};
  assign off_u = {{(XLEN-IMM_U_W){1'b0}}, word[21:10]} << scale;

  always_comb begin
    dec.legal   = common_ok && size_ok && (is_post || is_pre || is_uoff);
    dec.is64    = word[30];
    dec.rn      = word[9:5];
    dec.rt      = word[4:0];
    dec.base_sp = (word[9:5] == IDX_W'(SP_INDEX));
    if (is_post) begin
      dec.form   = FORM_POST;
      dec.offset = off_s;
    end else if (is_pre) begin
      dec.form   = FORM_PRE;
      dec.offset = off_s;
    end else if (is_uoff) begin
      dec.form   = FORM_UOFF;
      dec.offset = off_u;
    end else begin
      dec.form   = FORM_NONE;
      dec.offset = '0;
    end
    // write-back only in increment forms, dropped on base/destination overlap
    dec.wb_en = (is_post || is_pre) &&
                !((word[9:5] == word[4:0]) && (word[9:5] != IDX_W'(SP_INDEX)));
  end

  always_comb begin
    if (dec.legal && dec.form == FORM_UOFF)
      AST_UOFF_WORD_MULT : assert (dec.offset[1:0] == 2'b00); // R4
  end
endmodule

// File: rtl/ldimm_agen.sv
module ldimm_agen
  import ldimm_pkg::*;
#(
  parameter int AW        = XLEN,
  parameter int ALIGN_LG2 = 4
) (
  input  form_e         form,
  input  logic          base_sp,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] gpr_base,
  input  logic [AW-1:0] sp_base,
  output logic [AW-1:0] req_addr,
  output logic [AW-1:0] wb_addr,
  output logic          misalign
);
  logic [AW-1:0] base;
  logic [AW-1:0] sum;

  assign base     = base_sp ? sp_base : gpr_base;
  assign sum      = base + offset;
  assign wb_addr  = sum;
  assign req_addr = (form == FORM_POST) ? base : sum;
  assign misalign = base_sp && (|base[ALIGN_LG2-1:0]);
endmodule

// File: rtl/ldimm_ctrl.sv
module ldimm_ctrl
  import ldimm_pkg::*;
#(
  parameter int AW = XLEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_word,
  output logic [31:0]      word_q,
  input  logic             legal,
  input  logic             is64,
  input  logic [IDX_W-1:0] rn,
  input  logic [IDX_W-1:0] rt,
  input  logic             wb_en,
  input  logic             base_sp,
  input  logic [AW-1:0]    req_addr,
  input  logic [AW-1:0]    wb_addr,
  input  logic             misalign,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic [AW-1:0]    mreq_addr,
  output logic             mreq_dw,
  input  logic             mrsp_valid,
  output logic             mrsp_ready,
  input  logic [AW-1:0]    mrsp_data,
  output logic             dst_we,
  output logic [IDX_W-1:0] dst_idx,
  output logic [AW-1:0]    dst_data,
  output logic             base_we,
  output logic             base_is_sp,
  output logic [IDX_W-1:0] base_idx,
  output logic [AW-1:0]    base_data,
  output logic             flt_align,
  output logic             flt_undef
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_REQ, S_WAIT} state_e;
  localparam int HALF = AW / 2;

  state_e           state;
  logic [AW-1:0]    addr_q;
  logic [AW-1:0]    wbv_q;
  logic             wb_q;
  logic             dw_q;
  logic [IDX_W-1:0] rt_q;
  logic [IDX_W-1:0] rn_q;
  logic             sp_q;

  assign in_ready   = (state == S_IDLE);
  assign mreq_valid = (state == S_REQ);
  assign mrsp_ready = (state == S_WAIT);
  assign mreq_addr  = addr_q;
  assign mreq_dw    = dw_q;
  assign dst_idx    = rt_q;
  assign base_idx   = rn_q;
  assign base_is_sp = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      word_q    <= '0;
      addr_q    <= '0;
      wbv_q     <= '0;
      wb_q      <= 1'b0;
      dw_q      <= 1'b0;
      rt_q      <= '0;
      rn_q      <= '0;
      sp_q      <= 1'b0;
      dst_we    <= 1'b0;
      dst_data  <= '0;
      base_we   <= 1'b0;
      base_data <= '0;
      flt_align <= 1'b0;
      flt_undef <= 1'b0;
    end else begin
      dst_we    <= 1'b0;
      base_we   <= 1'b0;
      flt_align <= 1'b0;
      flt_undef <= 1'b0;
      case (state)
        S_IDLE: begin
          if (in_valid) begin
            word_q <= in_word;
            state  <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (!legal) begin
            flt_undef <= 1'b1;
            state     <= S_IDLE;
          end else if (misalign) begin
            flt_align <= 1'b1;
            state     <= S_IDLE;
          end else begin
            addr_q <= req_addr;
            wbv_q  <= wb_addr;
            wb_q   <= wb_en;
            dw_q   <= is64;
            rt_q   <= rt;
            rn_q   <= rn;
            sp_q   <= base_sp;
            state  <= S_REQ;
          end
        end
        S_REQ: begin
          if (mreq_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (mrsp_valid) begin
            dst_we    <= 1'b1;
            dst_data  <= dw_q ? mrsp_data : {{HALF{1'b0}}, mrsp_data[HALF-1:0]};
            base_we   <= wb_q;
            base_data <= wbv_q;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_STABLE : assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_dw))); // R9
  AST_BUSY_NO_ACCEPT : assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mreq_valid && !mrsp_ready)); // R9
  AST_WE_SINGLE : assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |=> !dst_we); // R10
  AST_BASE_WITH_DST : assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> dst_we); // R10
  AST_NO_OVERLAP_WB : assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> (base_is_sp || (base_idx != dst_idx))); // R8
  AST_FAULT_QUIET : assert property (@(posedge clk) disable iff (!rst_n)
    flt_align |-> (!mreq_valid && !dst_we && !base_we)); // R6
  AST_UNDEF_QUIET : assert property (@(posedge clk) disable iff (!rst_n)
    flt_undef |-> (!mreq_valid && !dst_we && !flt_align)); // R1
endmodule

// File: rtl/ldimm_agu.sv
module ldimm_agu
  import ldimm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_word,
  output logic [IDX_W-1:0] rf_rd_idx,
  input  logic [XLEN-1:0]  rf_rd_data,
  input  logic [XLEN-1:0]  sp_value,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic [XLEN-1:0]  mreq_addr,
  output logic             mreq_dw,
  input  logic             mrsp_valid,
  output logic             mrsp_ready,
  input  logic [XLEN-1:0]  mrsp_data,
  output logic             dst_we,
  output logic [IDX_W-1:0] dst_idx,
  output logic [XLEN-1:0]  dst_data,
  output logic             base_we,
  output logic             base_is_sp,
  output logic [IDX_W-1:0] base_idx,
  output logic [XLEN-1:0]  base_data,
  output logic             flt_align,
  output logic             flt_undef
);
  logic [31:0]     word_q;
  dec_t            dec;
  logic [XLEN-1:0] req_addr;
  logic [XLEN-1:0] wb_addr;
  logic            misalign;

  assign rf_rd_idx = dec.rn;

  ldimm_decode u_dec (
    .word (word_q),
    .dec  (dec)
  );

  ldimm_agen #(.AW(XLEN), .ALIGN_LG2(4)) u_agen (
    .form     (dec.form),
    .base_sp  (dec.base_sp),
    .offset   (dec.offset),
    .gpr_base (rf_rd_data),
    .sp_base  (sp_value),
    .req_addr (req_addr),
    .wb_addr  (wb_addr),
    .misalign (misalign)
  );

  ldimm_ctrl #(.AW(XLEN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .word_q     (word_q),
    .legal      (dec.legal),
    .is64       (dec.is64),
    .rn         (dec.rn),
    .rt         (dec.rt),
    .wb_en      (dec.wb_en),
    .base_sp    (dec.base_sp),
    .req_addr   (req_addr),
    .wb_addr    (wb_addr),
    .misalign   (misalign),
    .mreq_valid (mreq_valid),
    .mreq_ready (mreq_ready),
    .mreq_addr  (mreq_addr),
    .mreq_dw    (mreq_dw),
    .mrsp_valid (mrsp_valid),
    .mrsp_ready (mrsp_ready),
    .mrsp_data  (mrsp_data),
    .dst_we     (dst_we),
    .dst_idx    (dst_idx),
    .dst_data   (dst_data),
    .base_we    (base_we),
    .base_is_sp (base_is_sp),
    .base_idx   (base_idx),
    .base_data  (base_data),
    .flt_align  (flt_align),
    .flt_undef  (flt_undef)
  );
endmodule

// File: tb/test_ldimm_agu.sv
module test_ldimm_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [4:0]  rf_rd_idx;
  logic [63:0] rf_rd_data = '0;
  logic [63:0] sp_value = '0;
  logic        mreq_valid;
  logic        mreq_ready = 1'b0;
  logic [63:0] mreq_addr;
  logic        mreq_dw;
  logic        mrsp_valid = 1'b0;
  logic        mrsp_ready;
  logic [63:0] mrsp_data = '0;
  logic        dst_we;
  logic [4:0]  dst_idx;
  logic [63:0] dst_data;
  logic        base_we;
  logic        base_is_sp;
  logic [4:0]  base_idx;
  logic [63:0] base_data;
  logic        flt_align;
  logic        flt_undef;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ldimm_agu i_ldimm_agu (.*);

  localparam logic [63:0] RSP = 64'hCAFE_F00D_1234_5678;

  typedef struct packed {
    logic [1:0]  kind;   // 0 post, 1 pre, 2 scaled
    logic [1:0]  size;
    logic [11:0] imm;
    logic [4:0]  rn;
    logic [4:0]  rt;
    logic [63:0] base;
    logic [63:0] addr;
    logic        wb;
    logic [63:0] wbv;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TV [NV] = '{
    '{2'd0, 2'b11, 12'h010,  5'd2,  5'd3, 64'h1000, 64'h1000, 1'b1, 64'h1010},
    '{2'd0, 2'b10, 12'h100,  5'd4,  5'd5, 64'h2000, 64'h2000, 1'b1, 64'h1F00},
    '{2'd1, 2'b11, 12'h0FF,  5'd6,  5'd7, 64'h0100, 64'h01FF, 1'b1, 64'h01FF},
    '{2'd1, 2'b10, 12'h1F8, 5'd31,  5'd1, 64'h8000, 64'h7FF8, 1'b1, 64'h7FF8},
    '{2'd2, 2'b10, 12'hFFF,  5'd8,  5'd9, 64'h10000, 64'h13FFC, 1'b0, 64'h0},
    '{2'd2, 2'b11, 12'hFFF, 5'd31,  5'd2, 64'h0040, 64'h8038, 1'b0, 64'h0},
    '{2'd2, 2'b11, 12'h000, 5'd10, 5'd10, 64'h0123, 64'h0123, 1'b0, 64'h0},
    '{2'd0, 2'b11, 12'h008, 5'd12, 5'd12, 64'h0500, 64'h0500, 1'b0, 64'h0},
    '{2'd1, 2'b10, 12'h004, 5'd31, 5'd31, 64'h9000, 64'h9004, 1'b1, 64'h9004},
    '{2'd0, 2'b11, 12'h010,  5'd1,  5'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1, 64'h0}
  };

  function automatic logic [31:0] mkword(input logic [1:0] kind, input logic [1:0] size,
                                         input logic [11:0] imm, input logic [4:0] rn,
                                         input logic [4:0] rt);
    case (kind)
      2'd0:    return {size, 3'b111, 1'b0, 2'b00, 2'b01, 1'b0, imm[8:0], 2'b01, rn, rt};
      2'd1:    return {size, 3'b111, 1'b0, 2'b00, 2'b01, 1'b0, imm[8:0], 2'b11, rn, rt};
      default: return {size, 3'b111, 1'b0, 2'b01, 2'b01, imm, rn, rt};
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // kind_exp: 0 normal, 1 undefined, 2 alignment fault
  task automatic run(input logic [31:0] w, input logic [63:0] gpr, input logic [63:0] sp,
                     input int kind_exp, input logic [63:0] eaddr, input logic edw,
                     input logic ewb, input logic [63:0] ewbv, input int stall);
    logic [63:0] edata;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; rf_rd_data = gpr; sp_value = sp;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "in_ready busy", {63'd0, in_ready}, 64'd0);
    chk("R5", "rf_rd_idx", {59'd0, rf_rd_idx}, {59'd0, w[9:5]});
    @(negedge clk);
    if (kind_exp == 1) begin
      chk("R1", "flt_undef", {63'd0, flt_undef}, 64'd1);
      chk("R1", "no request", {63'd0, mreq_valid}, 64'd0);
      @(negedge clk);
      chk("R1", "no write", {62'd0, dst_we, base_we}, 64'd0);
      return;
    end
    if (kind_exp == 2) begin
      chk("R6", "flt_align", {63'd0, flt_align}, 64'd1);
      chk("R6", "no request", {63'd0, mreq_valid}, 64'd0);
      @(negedge clk);
      chk("R6", "no write", {62'd0, dst_we, base_we}, 64'd0);
      return;
    end
    chk("R2-4 addr", "mreq_addr", mreq_addr, eaddr);
    chk("R7", "mreq_dw", {63'd0, mreq_dw}, {63'd0, edw});
    chk("R9", "mreq_valid", {63'd0, mreq_valid}, 64'd1);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R9", "held valid", {63'd0, mreq_valid}, 64'd1);
      chk("R9", "held addr", mreq_addr, eaddr);
    end
    mreq_ready = 1'b1;
    @(negedge clk);
    mreq_ready = 1'b0;
    chk("R9", "request dropped", {63'd0, mreq_valid}, 64'd0);
    chk("R10", "mrsp_ready", {63'd0, mrsp_ready}, 64'd1);
    chk("R10", "no early write", {63'd0, dst_we}, 64'd0);
    mrsp_valid = 1'b1; mrsp_data = RSP;
    @(negedge clk);
    mrsp_valid = 1'b0;
    edata = edw ? RSP : {32'd0, RSP[31:0]};
    chk("R10", "dst_we", {63'd0, dst_we}, 64'd1);
    chk("R7", "dst_data", dst_data, edata);
    chk("R10", "dst_idx", {59'd0, dst_idx}, {59'd0, w[4:0]});
    chk("R8 wb", "base_we", {63'd0, base_we}, {63'd0, ewb});
    if (ewb) begin
      chk("R2 R3 wb", "base_data", base_data, ewbv);
      chk("R5", "base_is_sp", {63'd0, base_is_sp}, {63'd0, (w[9:5] == 5'd31)});
      chk("R5", "base_idx", {59'd0, base_idx}, {59'd0, w[9:5]});
    end
    @(negedge clk);
    chk("R10", "pulse end", {62'd0, dst_we, base_we}, 64'd0);
    chk("R9", "ready again", {63'd0, in_ready}, 64'd1);
  endtask

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    // reset state
    chk("R9", "reset in_ready", {63'd0, in_ready}, 64'd1);
    chk("R9", "reset mreq_valid", {63'd0, mreq_valid}, 64'd0);
    chk("R10", "reset writes", {62'd0, dst_we, base_we}, 64'd0);
    chk("R1", "reset flags", {62'd0, flt_align, flt_undef}, 64'd0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      w = mkword(TV[i].kind, TV[i].size, TV[i].imm, TV[i].rn, TV[i].rt);
      run(w, (TV[i].rn == 5'd31) ? 64'hDEAD : TV[i].base,
          (TV[i].rn == 5'd31) ? TV[i].base : 64'hBEEF0,
          0, TV[i].addr, TV[i].size[0], TV[i].wb, TV[i].wbv, i % 3);
    end

    // R9: long back-pressure on a request
    run(mkword(2'd1, 2'b11, 12'h020, 5'd3, 5'd4), 64'h4000, 64'h0, 0,
        64'h4020, 1'b1, 1'b1, 64'h4020, 6);

    // R1: undefined encodings
    run(mkword(2'd0, 2'b00, 12'h010, 5'd2, 5'd3), 64'h1000, 64'h0, 1, 0, 0, 0, 0, 0);
    run(mkword(2'd2, 2'b01, 12'h010, 5'd2, 5'd3), 64'h1000, 64'h0, 1, 0, 0, 0, 0, 0);
    run(mkword(2'd0, 2'b11, 12'h010, 5'd2, 5'd3) | 32'h0400_0000, 64'h1000, 64'h0, 1, 0, 0, 0, 0, 0);
    run(mkword(2'd0, 2'b11, 12'h010, 5'd2, 5'd3) & ~32'h0000_0400, 64'h1000, 64'h0, 1, 0, 0, 0, 0, 0);
    run(mkword(2'd0, 2'b11, 12'h010, 5'd2, 5'd3) | 32'h0020_0000, 64'h1000, 64'h0, 1, 0, 0, 0, 0, 0);
    run(mkword(2'd2, 2'b11, 12'h010, 5'd2, 5'd3) | 32'h0080_0000, 64'h1000, 64'h0, 1, 0, 0, 0, 0, 0);

    // R6: misaligned stack base in increment and scaled forms
    run(mkword(2'd0, 2'b11, 12'h010, 5'd31, 5'd3), 64'h0, 64'h8008, 2, 0, 0, 0, 0, 0);
    run(mkword(2'd2, 2'b10, 12'h001, 5'd31, 5'd3), 64'h0, 64'h8004, 2, 0, 0, 0, 0, 0);

    // recovery after faults, R2
    run(mkword(2'd0, 2'b10, 12'h1FF, 5'd7, 5'd8), 64'h3000, 64'h0, 0,
        64'h3000, 1'b0, 1'b1, 64'h2FFF, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule